// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a memory port and judges every access against eight programmable address windows. Each window has an inclusive lower and upper bound, rounded to 32-byte granules, a valid flag and a 12-bit permission mask. The mask gives separate read, write and execute grants for each of four master identifiers. An access presents an address, a master identifier and an access kind. In the same cycle the block answers with a single protection-fault flag. When windows overlap, a grant from any one of them is enough to allow the access. An access that lands in no active window is always a fault.

Software fills the windows through a small word-wide write port and then sets a global enable. Until the enable is set, nothing is ever flagged. The first fault is recorded: its address, master and kind are held, and a sticky flag is raised. That record stays frozen until software clears the flag by writing a one.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset the global enable is 0, every window is invalid, and `prot_err`, `err_sticky`, `err_addr`, `err_master` and `err_kind` are all 0.
- R2: While the global enable is 0, `prot_err` stays 0 for any access. No fault details are recorded in that state.
- R3: With the enable set, a valid access that lies in no valid window raises `prot_err` combinationally, in the same cycle.
- R4: A window covers an address A when `{lo[31:5],5'b0} <= A <= {hi[31:5],5'b11111}`. The low five bits of both bounds are ignored.
- R5: When exactly one window covers the access, `prot_err` is 1 only if that window's grant bit is 0. The grant bit sits at position `3*master + kind` of the mask, with kind encoded as read=0, write=1 and execute=2.
- R6: When several windows cover the access, `prot_err` is 1 only if every covering window denies it. A single grant clears the fault.
- R7: A window whose valid flag is 0 never covers any address, whatever its bounds and mask.
- R8: Write port map on `cfg_addr`. For addresses 0 to 31, `cfg_addr[4:2]` selects the window and `cfg_addr[1:0]` selects the word: 0 holds the lower bound, 1 the upper bound, 2 the mask in `wdata[11:0]`, and 3 the valid flag in `wdata[0]`. Writing address 32 loads the enable from `wdata[0]`. Writing address 33 with `wdata[0]=1` clears the sticky flag.
- R9: On a faulting access while the sticky flag is 0, the next clock edge sets `err_sticky` and captures the address, master and kind. While the flag stays set, later faults leave those details unchanged.
- R10: A clear write with `wdata[0]=0` has no effect. When a clear write and a fault fall in the same cycle, the fault wins: the sticky flag stays 1 and the new details are captured.
- R11: Access kind code 3 is never granted by any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_master | input | 2 | Master identifier |
| acc_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| prot_err | output | 1 | Combinational protection fault for the current access |
| err_sticky | output | 1 | Sticky fault flag |
| err_addr | output | 32 | Address of the recorded fault |
| err_master | output | 2 | Master of the recorded fault |
| err_kind | output | 2 | Kind of the recorded fault |

## Verification
A corrupted bound, mask or valid flag shows up on `prot_err` in the very cycle that an access touches the affected granule, master or kind. The stimulus therefore probes both edges of each window, and the overlap between two windows, with several masters. A wrong capture or clear shows up one edge later, on `err_sticky` and the recorded details. For this reason, repeated faults and clears that coincide with a fault are each followed by a look at those outputs on the next falling edge.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;
  localparam int ADDR_W    = 32;
  localparam int GRAN_BITS = 5;
  localparam int MST_W     = 2;
  localparam int NUM_MST   = 1 << MST_W;
  localparam int KIND_BITS = 3;
  localparam int PERM_W    = KIND_BITS * NUM_MST;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic [PERM_W-1:0] perm;
    logic              valid;
  } region_t;

  // Granule-aligned inclusive window test
  function automatic logic in_window(logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] lo,
                                     logic [ADDR_W-1:0] hi);
    logic [ADDR_W-1:0] gmask;
    gmask = (ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1);
    return (a >= (lo & ~gmask)) && (a <= (hi | gmask));
  endfunction

  // Grant bit lookup: mask bit 3*master + kind, reserved kind never granted
  function automatic logic perm_grant(logic [PERM_W-1:0] perm,
                                      logic [MST_W-1:0]  mst,
                                      logic [1:0]        kind);
    if (kind == ACC_RSVD) return 1'b0;
    return perm[KIND_BITS * int'(mst) + int'(kind)];
  endfunction
endpackage

// File: rtl/mpu_desc_bank.sv
module mpu_desc_bank
  import mpu_guard_pkg::*;
#(
  parameter int N_REGIONS = 8,
  localparam int IDX_W  = $clog2(N_REGIONS),
  localparam int CFG_AW = IDX_W + 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  output region_t [N_REGIONS-1:0]       regions,
  output logic                          en_q,
  output logic                          clr_pulse
);
  logic ctrl_sel;
  assign ctrl_sel  = cfg_we && cfg_addr[CFG_AW-1];
  assign clr_pulse = ctrl_sel && (cfg_addr[1:0] == 2'd1) && cfg_wdata[0];

  region_t regs_q [N_REGIONS];

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_desc
    logic sel;
    assign sel = cfg_we && !cfg_addr[CFG_AW-1] && (cfg_addr[IDX_W+1:2] == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (sel) begin
        case (cfg_addr[1:0])
          2'd0:    regs_q[g].lo    <= cfg_wdata;
          2'd1:    regs_q[g].hi    <= cfg_wdata;
          2'd2:    regs_q[g].perm  <= cfg_wdata[PERM_W-1:0];
          default: regs_q[g].valid <= cfg_wdata[0];
        endcase
      end
    end
    assign regions[g] = regs_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else if (ctrl_sel && cfg_addr[1:0] == 2'd0) en_q <= cfg_wdata[0];
  end

  // R8
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel && cfg_addr[1:0] == 2'd0) |=> (en_q == $past(cfg_wdata[0])));
endmodule

// File: rtl/mpu_region_eval.sv
module mpu_region_eval
  import mpu_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  region_t           rgn,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [MST_W-1:0]  acc_master,
  input  logic [1:0]        acc_kind,
  output logic              no_hit,
  output logic              violation
);
  assign no_hit    = !(rgn.valid && in_window(acc_addr, rgn.lo, rgn.hi));
  assign violation = !perm_grant(rgn.perm, acc_master, acc_kind);

  // R7
  invalid_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rgn.valid |-> no_hit);

  // R4
  lo_granule_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgn.valid && rgn.lo[ADDR_W-1:GRAN_BITS] <= rgn.hi[ADDR_W-1:GRAN_BITS]
     && acc_addr[ADDR_W-1:GRAN_BITS] == rgn.lo[ADDR_W-1:GRAN_BITS]) |-> !no_hit);

  // R11
  rsvd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_RSVD) |-> violation);
endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard
  import mpu_guard_pkg::*;
#(
  parameter int N_REGIONS = 8,
  localparam int CFG_AW = $clog2(N_REGIONS) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic [1:0]        acc_master,
  input  logic [1:0]        acc_kind,
  output logic              prot_err,
  output logic              err_sticky,
  output logic [31:0]       err_addr,
  output logic [1:0]        err_master,
  output logic [1:0]        err_kind
);
  region_t [N_REGIONS-1:0] regions;
  logic                    en_q;
  logic                    clr_pulse;
  logic [N_REGIONS-1:0]    hit_vec;
  logic [N_REGIONS-1:0]    grant_vec;
  logic [N_REGIONS-1:0]    fault_vec;

  mpu_desc_bank #(.N_REGIONS(N_REGIONS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .regions   (regions),
    .en_q      (en_q),
    .clr_pulse (clr_pulse)
  );

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_eval
    logic nh, vi;
    mpu_region_eval u_eval (
      .clk        (clk),
      .rst_n      (rst_n),
      .rgn        (regions[g]),
      .acc_addr   (acc_addr),
      .acc_master (acc_master),
      .acc_kind   (acc_kind),
      .no_hit     (nh),
      .violation  (vi)
    );
    assign hit_vec[g]   = !nh;
    assign grant_vec[g] = !nh && !vi;
    assign fault_vec[g] = nh || vi;
  end

  // Any granting window wins: fault only when every window misses or denies
  logic err_evt;
  assign err_evt  = en_q && acc_valid && (&fault_vec);
  assign prot_err = err_evt;

  logic capture;
  assign capture = err_evt && (!err_sticky || clr_pulse);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sticky <= 1'b0;
      err_addr   <= '0;
      err_master <= '0;
      err_kind   <= '0;
    end else begin
      err_sticky <= err_evt || (err_sticky && !clr_pulse);
      if (capture) begin
        err_addr   <= acc_addr;
        err_master <= acc_master;
        err_kind   <= acc_kind;
      end
    end
  end

  // R3
  miss_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && en_q && hit_vec == '0) |-> prot_err);

  // R6
  any_grant_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> !prot_err);

  // R9
  fault_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> err_sticky);

  // R9
  details_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && $past(err_sticky) && !$past(clr_pulse)) |-> $stable(err_addr));

  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !prot_err) |=> !err_sticky);
endmodule

// File: tb/mpu_region_guard_bench.sv
module mpu_region_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_master = '0;
  logic [1:0]  acc_kind = '0;
  logic        prot_err, err_sticky;
  logic [31:0] err_addr;
  logic [1:0]  err_master, err_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_guard u_mpu_region_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_master(acc_master), .acc_kind(acc_kind), .prot_err(prot_err),
    .err_sticky(err_sticky), .err_addr(err_addr), .err_master(err_master),
    .err_kind(err_kind));

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // Independent reference of the window table
  logic [31:0] m_lo [NR];
  logic [31:0] m_hi [NR];
  logic [11:0] m_perm [NR];
  logic        m_vld [NR];
  logic        m_en = 1'b0;

  logic  exp_q [$];
  string tag_q [$];
  event  mon_ev;

  function automatic logic model_err(logic [31:0] a, int m, int k);
    logic ok;
    ok = 1'b0;
    if (!m_en) return 1'b0;
    for (int r = 0; r < NR; r++) begin
      if (m_vld[r] && (a / 32) >= (m_lo[r] / 32) && (a / 32) <= (m_hi[r] / 32)
          && k != 3 && m_perm[r][m*3 + k])
        ok = 1'b1;
    end
    return !ok;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected fault flag and compares
  initial begin
    forever begin
      @(mon_ev);
      if (exp_q.size() > 0) begin
        automatic logic  e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {31'd0, prot_err}, {31'd0, e});
      end
    end
  end

  task automatic cfg_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 6'h20) m_en = d[0];
  endtask

  task automatic prog_region(int r, logic [31:0] lo, logic [31:0] hi,
                             logic [11:0] perm, logic vld);
    cfg_write(6'(r*4 + 0), lo);
    cfg_write(6'(r*4 + 1), hi);
    cfg_write(6'(r*4 + 2), {20'd0, perm});
    cfg_write(6'(r*4 + 3), {31'd0, vld});
    m_lo[r] = lo; m_hi[r] = hi; m_perm[r] = perm; m_vld[r] = vld;
  endtask

  // Driver: drives one access, optionally with a clear write in the same cycle
  task automatic access(string req, logic [31:0] a, int m, int k, bit with_clr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_master = 2'(m); acc_kind = 2'(k);
    if (with_clr) begin cfg_we = 1'b1; cfg_addr = 6'h21; cfg_wdata = 32'd1; end
    exp_q.push_back(model_err(a, m, k));
    tag_q.push_back(req);
    #(CLK_PERIOD/4);
    -> mon_ev;
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_lo[r] = '0; m_hi[r] = '0; m_perm[r] = '0; m_vld[r] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sticky", {31'd0, err_sticky}, 32'd0);
    check("R1 addr", err_addr, 32'd0);
    check("R1 master/kind", {28'd0, err_master, err_kind}, 32'd0);
    // R1 R2: disabled after reset, no windows, no fault
    access("R2 disabled miss", 32'h0000_0040, 0, 0, 0);
    check("R2 no capture", {31'd0, err_sticky}, 32'd0);

    // R8 map: window 0 RW for master 0; window 1 exec m0, read m1
    prog_region(0, 32'h0000_1000, 32'h0000_1FFF, 12'b000_000_000_011, 1'b1);
    prog_region(1, 32'h0000_1800, 32'h0000_27E0, 12'b000_000_001_100, 1'b1);
    prog_region(2, 32'h0000_5003, 32'h0000_5040, 12'hFFF, 1'b0);
    prog_region(3, 32'h0000_8000, 32'h0000_80FF, 12'hFFF, 1'b1);
    cfg_write(6'h20, 32'd1);

    access("R5 single grant read", 32'h0000_1000, 0, 0, 0);
    access("R5 single deny exec", 32'h0000_1000, 0, 2, 0);
    // R9 first fault captured
    check("R9 sticky set", {31'd0, err_sticky}, 32'd1);
    check("R9 addr", err_addr, 32'h0000_1000);
    check("R9 master/kind", {28'd0, err_master, err_kind}, {28'd0, 2'd0, 2'd2});
    access("R3 below window", 32'h0000_0FFF, 0, 0, 0);
    check("R9 details held", err_addr, 32'h0000_1000);
    access("R5 top edge write", 32'h0000_1FFF, 0, 1, 0);
    access("R6 overlap one grants", 32'h0000_1900, 0, 2, 0);
    access("R6 overlap all deny", 32'h0000_1900, 1, 1, 0);
    access("R6 overlap m1 read", 32'h0000_1900, 1, 0, 0);
    access("R4 end low bits forced", 32'h0000_27FF, 1, 0, 0);
    access("R4 past end granule", 32'h0000_2800, 1, 0, 0);
    access("R4 start low bits forced", 32'h0000_1800, 1, 0, 0);
    access("R7 invalid window", 32'h0000_5000, 0, 0, 0);
    access("R5 m2 exec", 32'h0000_8004, 2, 2, 0);
    access("R5 m3 write", 32'h0000_80FF, 3, 1, 0);
    access("R11 reserved kind", 32'h0000_8004, 2, 3, 0);

    // R10 clear semantics
    cfg_write(6'h21, 32'd0);
    check("R10 zero write ignored", {31'd0, err_sticky}, 32'd1);
    cfg_write(6'h21, 32'd1);
    check("R10 cleared", {31'd0, err_sticky}, 32'd0);
    access("R10 fault with clear", 32'h0000_2800, 1, 0, 1);
    check("R10 fault beats clear", {31'd0, err_sticky}, 32'd1);
    check("R10 new addr", err_addr, 32'h0000_2800);
    access("R10 fault with clear on set flag", 32'h0000_5000, 0, 0, 1);
    check("R10 recaptured addr", err_addr, 32'h0000_5000);
    check("R10 recaptured master/kind", {28'd0, err_master, err_kind}, 32'd0);

    // R2 disable again
    cfg_write(6'h20, 32'd0);
    access("R2 disabled no fault", 32'h0000_0000, 0, 0, 0);
    check("R2 details untouched", err_addr, 32'h0000_5000);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule